// File: doc/BRIEF.md
# Receive Word Expander and Justifier

This block sits behind a serial receiver and turns each completed receive word into the word software reads. It accepts the raw shifted-in word, a code giving how many bits that word holds, a formatting mode and a justification choice. One clock later it presents the formatted word, together with a valid strobe.

Four formatting modes are available. The first passes the raw word through a justifier, which can right-justify it with zero fill, right-justify it with sign extension, or left-justify it with zero fill. The second reverses an 8-bit word that arrived least significant bit first and then justifies it. The remaining two expand an 8-bit G.711 code, either mu-law or A-law, into linear two's-complement data. Both companded modes force an 8-bit word and ignore the justification choice.

The output width is a parameter, 16 bits by default. Companded results always occupy the top 16 bits of the output word.

Top module: `rx_word_formatter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. While `rst_n` is low, `out_valid` and `out_word` are cleared to zero.
- R2: `out_word` changes only in the cycle after a cycle with `in_valid` high. Otherwise it keeps its value.
- R3: The length code `in_len` maps 0 to 8 bits, 1 to 12, 2 to 16, 3 to 20, 4 to 24, and 5, 6 and 7 to 32. In raw mode (`in_cmode` = 00), `in_just` = 00 gives the low length bits of `in_word` right-justified, with every higher output bit zero.
- R4: In raw mode, `in_just` = 01 right-justifies the word and fills every higher output bit with the word's top bit. For example, 0xABC at 12 bits gives 0xFABC.
- R5: In raw mode, `in_just` = 10 or 11 places the word's top bit at the output MSB and zero-fills below it. For example, 0xABC at 12 bits gives 0xABC0.
- R6: A word longer than the output keeps its low output-width bits when right-justified and its top output-width bits when left-justified. For example, 0xABCDE at 20 bits gives 0xBCDE or 0xABCD.
- R7: `in_cmode` = 01 takes only `in_word[7:0]`, reverses its bit order, and justifies the result as an 8-bit word under `in_just`, whatever `in_len` says.
- R8: `in_cmode` = 10 expands `in_word[7:0]` as mu-law. The complemented code has sign in bit 7 (1 = negative), exponent e in bits 6:4 and mantissa m in bits 3:0. The magnitude is 4*((2m+33)*2^e - 33), which gives a range of +/-32124. The 16-bit result sits in the top bits of the output and the lower bits are zero.
- R9: `in_cmode` = 11 expands `in_word[7:0]` as A-law. The code XOR 0x55 has sign in bit 7 (1 = positive), segment s in bits 6:4 and mantissa m in bits 3:0. The magnitude is 16m+8 for s = 0 and 8*(2m+33)*2^(s-1) otherwise. Placement is as in R8.
- R10: In the companded modes, `in_len`, `in_just` and `in_word` bits above 7 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A completed receive word is presented |
| in_word | input | IN_W | Raw received word, right-aligned |
| in_len | input | 3 | Word length code |
| in_cmode | input | 2 | Formatting mode: raw, LSB-first, mu-law, A-law |
| in_just | input | 2 | Justification for raw and LSB-first modes |
| out_valid | output | 1 | Formatted word valid |
| out_word | output | OUT_W | Formatted word |

## Verification
The hardest cases to reach are words longer than the output and companded words that carry garbage. In the second case the upper bits, length code and justification select are all non-zero, and any leak of them would show. Directed vectors first cover the fixed examples and the end points of both expansion laws. Random vectors then draw every length code, mode and justify value with random full-width words. Idle gaps are interleaved at random so that the hold behaviour is checked between words.

// File: rtl/rxfmt_pkg.sv
// Package: shared encodings for the receive word formatter.
// Assumes word lengths never exceed 32 bits.
package rxfmt_pkg;

    typedef enum logic [1:0] {
        CM_RAW    = 2'b00,
        CM_LSBF   = 2'b01,
        CM_MULAW  = 2'b10,
        CM_ALAW   = 2'b11
    } cmode_t;

    typedef enum logic [1:0] {
        JS_RZERO = 2'b00,
        JS_RSIGN = 2'b01,
        JS_LZERO = 2'b10,
        JS_LZALT = 2'b11
    } just_t;

    localparam int LEN_W = 6;

    // Translate the 3-bit length code into a bit count.
    function automatic logic [LEN_W-1:0] len_to_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd8;
            3'd1:    return 6'd12;
            3'd2:    return 6'd16;
            3'd3:    return 6'd20;
            3'd4:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/rxfmt_mulaw.sv
// Module: combinational mu-law to 16-bit linear expander.
// Assumes an 8-bit G.711 mu-law code; output is two's complement, +/-32124.
module rxfmt_mulaw (
    input  logic [7:0]  code,
    output logic [15:0] lin
);
    logic [7:0]  inv;
    logic [15:0] mag;
    logic [15:0] base;

    // Invert the code, rebuild the biased magnitude and apply the sign.
    always_comb begin
        inv  = ~code;
        base = 16'({inv[3:0], 3'b000}) + 16'h0084;
        mag  = (base << inv[6:4]) - 16'h0084;
        lin  = inv[7] ? (16'h0000 - mag) : mag;
    end
endmodule

// File: rtl/rxfmt_alaw.sv
// Module: combinational A-law to 16-bit linear expander.
// Assumes an 8-bit G.711 A-law code; output is two's complement, +/-32256.
module rxfmt_alaw (
    input  logic [7:0]  code,
    output logic [15:0] lin
);
    logic [7:0]  tog;
    logic [15:0] mag;
    logic [15:0] step;

    // Undo the even-bit toggling, then rebuild the magnitude per segment.
    always_comb begin
        tog  = code ^ 8'h55;
        step = 16'({tog[3:0], 4'b0000});
        if (tog[6:4] == 3'd0) begin
            mag = step + 16'h0008;
        end else begin
            mag = (step + 16'h0108) << (tog[6:4] - 3'd1);
        end
        lin = tog[7] ? mag : (16'h0000 - mag);
    end
endmodule

// File: rtl/rxfmt_justify.sv
// Module: places an n-bit right-aligned word into the output width.
// Assumes 8 <= nbits <= IN_W and OUT_W <= IN_W.
module rxfmt_justify #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]           word,
    input  logic [rxfmt_pkg::LEN_W-1:0] nbits,
    input  logic [1:0]                just,
    output logic [OUT_W-1:0]          result
);
    import rxfmt_pkg::*;

    localparam logic [LEN_W-1:0] IN_BITS = LEN_W'(IN_W);

    logic [IN_W-1:0]  mask;
    logic [IN_W-1:0]  kept;
    logic [IN_W-1:0]  shifted;
    logic [IN_W-1:0]  signed_fill;
    logic [IN_W-1:0]  left_word;
    logic [LEN_W-1:0] lshift;
    logic             topbit;

    // Mask to the word length and find the word's top bit.
    always_comb begin
        mask    = (nbits >= IN_BITS) ? '1 : ((IN_W'(1) << nbits) - IN_W'(1));
        kept    = word & mask;
        shifted = word >> (nbits - LEN_W'(1));
        topbit  = shifted[0];
        signed_fill = topbit ? (kept | ~mask) : kept;
        lshift  = (nbits >= IN_BITS) ? '0 : (IN_BITS - nbits);
        left_word = kept << lshift;
    end

    // Choose the justification variant.
    always_comb begin
        case (just)
            JS_RZERO: result = kept[OUT_W-1:0];
            JS_RSIGN: result = signed_fill[OUT_W-1:0];
            default:  result = left_word[IN_W-1 -: OUT_W];
        endcase
    end
endmodule

// File: rtl/rx_word_formatter.sv
// Module: registered receive word formatter (raw justify, LSB-first, G.711).
// Assumes IN_W is 32 or less and 16 <= OUT_W <= IN_W; one word per cycle at most.
module rx_word_formatter #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_word,
    input  logic [2:0]       in_len,
    input  logic [1:0]       in_cmode,
    input  logic [1:0]       in_just,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word
);
    import rxfmt_pkg::*;

    localparam int PAD_W = OUT_W - 16;

    logic [7:0]       rev_byte;
    logic [IN_W-1:0]  just_src;
    logic [LEN_W-1:0] nbits;
    logic [OUT_W-1:0] just_out;
    logic [15:0]      mu_lin;
    logic [15:0]      a_lin;
    logic [OUT_W-1:0] next_word;

    // Bit reversal of the low byte for LSB-first words.
    for (genvar b = 0; b < 8; b++) begin : g_rev
        assign rev_byte[b] = in_word[7-b];
    end

    // Choose the justifier source and its effective length.
    always_comb begin
        if (in_cmode == CM_LSBF) begin
            just_src = IN_W'(rev_byte);
            nbits    = LEN_W'(8);
        end else begin
            just_src = in_word;
            nbits    = (len_to_bits(in_len) > LEN_W'(IN_W)) ? LEN_W'(IN_W)
                                                            : len_to_bits(in_len);
        end
    end

    rxfmt_justify #(.IN_W(IN_W), .OUT_W(OUT_W)) u_just (
        .word   (just_src),
        .nbits  (nbits),
        .just   (in_just),
        .result (just_out)
    );

    rxfmt_mulaw u_mu (.code(in_word[7:0]), .lin(mu_lin));
    rxfmt_alaw  u_a  (.code(in_word[7:0]), .lin(a_lin));

    // Select the final formatted word; companded results go to the top.
    always_comb begin
        case (in_cmode)
            CM_MULAW: next_word = OUT_W'(mu_lin) << PAD_W;
            CM_ALAW:  next_word = OUT_W'(a_lin) << PAD_W;
            default:  next_word = just_out;
        endcase
    end

    // Output register: strobe follows input by one cycle, word held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= next_word;
            end
        end
    end
endmodule

// File: rtl/rxfmt_chk.sv
// Module: temporal checks for rx_word_formatter, attached by bind.
// Assumes the same parameters as the block it watches.
module rxfmt_chk #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_word,
    input logic [2:0]       in_len,
    input logic [1:0]       in_cmode,
    input logic [1:0]       in_just,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0));

    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R3
    rzero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cmode == 2'b00 && in_len == 3'd0 && in_just == 2'b00)
        |=> out_word[OUT_W-1:8] == '0);

    // R5
    lzero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cmode == 2'b00 && in_len == 3'd0 && in_just[1])
        |=> out_word[OUT_W-9:0] == '0);

    // R8
    mulaw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cmode == 2'b10 && in_word[7:0] == 8'hFF)
        |=> out_word == '0);

    // R9
    alaw_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cmode == 2'b11 && in_word[7])
        |=> !out_word[OUT_W-1]);
endmodule

bind rx_word_formatter rxfmt_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/rx_word_formatter_test.sv
module rx_word_formatter_test;
    localparam int CLK_NS = 10;
    localparam int IW = 32;
    localparam int OW = 16;
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_word = '0;
    logic [2:0]    in_len = '0;
    logic [1:0]    in_cmode = '0;
    logic [1:0]    in_just = '0;
    logic          out_valid;
    logic [OW-1:0] out_word;

    int vectors = 0;
    int misses = 0;
    int cycles = 0;
    bit done = 0;

    logic          exp_valid = 1'b0;
    logic [OW-1:0] exp_word = '0;

    always #(CLK_NS/2) clk = ~clk;

    rx_word_formatter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_len(in_len), .in_cmode(in_cmode), .in_just(in_just),
        .out_valid(out_valid), .out_word(out_word)
    );

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    function automatic int bits_of(input logic [2:0] c);
        int t[8] = '{8, 12, 16, 20, 24, 32, 32, 32};
        return t[c];
    endfunction

    function automatic longint lin_to_out(input longint v);
        return ((v & 64'hFFFF) << (OW - 16)) & ((64'd1 << OW) - 1);
    endfunction

    function automatic longint mu_model(input logic [7:0] b);
        logic [7:0] c;
        longint mag;
        c = ~b;
        mag = 4 * ((2 * c[3:0] + 33) * (64'd1 << c[6:4]) - 33);
        return lin_to_out(c[7] ? -mag : mag);
    endfunction

    function automatic longint a_model(input logic [7:0] b);
        logic [7:0] c;
        longint mag;
        c = b ^ 8'h55;
        if (c[6:4] == 0) mag = 16 * c[3:0] + 8;
        else mag = 8 * (2 * c[3:0] + 33) * (64'd1 << (c[6:4] - 1));
        return lin_to_out(c[7] ? mag : -mag);
    endfunction

    function automatic longint just_model(input longint raw, input int n, input logic [1:0] js);
        longint val, omask;
        omask = (64'd1 << OW) - 1;
        val = raw & ((64'd1 << n) - 1);
        if (js == 2'b00) return val & omask;
        if (js == 2'b01) return (val[n-1] ? (val - (64'd1 << n)) : val) & omask;
        return ((val << (IW - n)) >> (IW - OW)) & omask;
    endfunction

    function automatic longint format_model(input logic [IW-1:0] w, input logic [2:0] len,
                                            input logic [1:0] cm, input logic [1:0] js);
        logic [7:0] r;
        case (cm)
            2'b10: return mu_model(w[7:0]);
            2'b11: return a_model(w[7:0]);
            2'b01: begin
                for (int i = 0; i < 8; i++) r[i] = w[7-i];
                return just_model(longint'(r), 8, js);
            end
            default: return just_model(longint'(w), bits_of(len), js);
        endcase
    endfunction

    task automatic check(input string tag);
        vectors++;
        if (out_valid !== exp_valid || out_word !== exp_word) begin
            misses++;
            $display("FAIL %s: actual valid=%b word=%h expected valid=%b word=%h",
                     tag, out_valid, out_word, exp_valid, exp_word);
        end
    endtask

    // One clock: drive at the falling edge, compare at the next falling edge.
    task automatic step(input logic v, input logic [IW-1:0] w, input logic [2:0] len,
                        input logic [1:0] cm, input logic [1:0] js, input string tag);
        in_valid = v; in_word = w; in_len = len; in_cmode = cm; in_just = js;
        exp_valid = v;
        if (v) exp_word = OW'(format_model(w, len, cm, js));
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic expect_word(input logic [IW-1:0] w, input logic [2:0] len,
                               input logic [1:0] cm, input logic [1:0] js,
                               input logic [OW-1:0] fixed, input string tag);
        step(1'b1, w, len, cm, js, tag);
        vectors++;
        if (out_word !== fixed) begin
            misses++;
            $display("FAIL %s fixed: actual %h expected %h", tag, out_word, fixed);
        end
    endtask

    function automatic string tag_for(input logic [1:0] cm, input logic [2:0] len,
                                      input logic [1:0] js);
        if (cm == 2'b10) return "R8/R10";
        if (cm == 2'b11) return "R9/R10";
        if (cm == 2'b01) return "R7";
        if (bits_of(len) > OW) return "R6";
        if (js == 2'b00) return "R3";
        if (js == 2'b01) return "R4";
        return "R5";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        exp_valid = 1'b0; exp_word = '0;
        check("R1 reset");
        rst_n = 1'b1;

        // R3 R4 R5: the 12-bit example under the three justifications.
        expect_word(32'h0000_0ABC, 3'd1, 2'b00, 2'b00, 16'h0ABC, "R3");
        expect_word(32'hFFFF_FABC, 3'd1, 2'b00, 2'b01, 16'hFABC, "R4");
        expect_word(32'h0000_0ABC, 3'd1, 2'b00, 2'b10, 16'hABC0, "R5");
        expect_word(32'h0000_0ABC, 3'd1, 2'b00, 2'b11, 16'hABC0, "R5");
        // R6: word wider than the output.
        expect_word(32'h000A_BCDE, 3'd3, 2'b00, 2'b00, 16'hBCDE, "R6");
        expect_word(32'h000A_BCDE, 3'd3, 2'b00, 2'b10, 16'hABCD, "R6");
        // R7: LSB-first reversal, length forced to 8.
        expect_word(32'hFFFF_FF01, 3'd5, 2'b01, 2'b00, 16'h0080, "R7");
        expect_word(32'h0000_0001, 3'd2, 2'b01, 2'b01, 16'hFF80, "R7");
        // R8: mu-law end points.
        expect_word(32'h0000_00FF, 3'd0, 2'b10, 2'b00, 16'h0000, "R8");
        expect_word(32'h0000_0000, 3'd0, 2'b10, 2'b00, 16'h8284, "R8");
        expect_word(32'h0000_0080, 3'd0, 2'b10, 2'b00, 16'h7D7C, "R8");
        // R9: A-law end points.
        expect_word(32'h0000_00D5, 3'd0, 2'b11, 2'b00, 16'h0008, "R9");
        expect_word(32'h0000_0055, 3'd0, 2'b11, 2'b00, 16'hFFF8, "R9");
        expect_word(32'h0000_002A, 3'd0, 2'b11, 2'b00, 16'h8200, "R9");
        // R10: garbage in length, justify and upper bits while companding.
        expect_word(32'hDEAD_BE80, 3'd6, 2'b10, 2'b11, 16'h7D7C, "R10");
        expect_word(32'h1234_56D5, 3'd3, 2'b11, 2'b01, 16'h0008, "R10");
        // R2: idle cycles hold the last word.
        step(1'b0, 32'hFFFF_FFFF, 3'd1, 2'b00, 2'b01, "R2");
        step(1'b0, 32'h0000_0000, 3'd0, 2'b01, 2'b10, "R2");

        // Random mix with idle gaps.
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] cm, js;
            logic [2:0] len;
            logic v;
            cm = 2'($urandom); js = 2'($urandom); len = 3'($urandom);
            v = ($urandom % 4) != 0;
            step(v, 32'($urandom), len, cm, js, v ? tag_for(cm, len, js) : "R2");
        end

        // R1: reset in mid-stream clears the output.
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        exp_valid = 1'b0; exp_word = '0;
        check("R1 reset");
        rst_n = 1'b1;
        in_valid = 1'b0;

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule